// File: doc/BRIEF.md
# Interconnect-Word to Scan-Chain Stimulus Loader

This block sits between a functional interconnect port that is reused for test access and a set of parallel wrapper chains of the module under test. Stimulus arrives as wide words at a fixed period. The block splits every word over `N_CH` chains so that each chain keeps shifting at one bit per clock. The chain count is the largest number of one-bit-per-clock streams that the port bandwidth can carry. The period is `P_IN = W_IN / N_CH` (integer division), and each chain takes `P_IN` bits from every word. The bits that do not divide evenly go to spare cells that feed no chain.

The head of each chain is a group of `P_IN` parallel-load input wrapper cells. A word is captured into these cells and then shifted out toward the rest of the chain during the following `P_IN` cycles. The next word should arrive in the last cycle of that window, so that shifting never pauses. If it is late, a one-cycle underrun pulse is raised and shifting waits. The final word of a pattern is not shifted: it stays in the cells and is applied to the module, and a one-cycle capture pulse follows.

Top module: `scan_stim_loader`

## Requirements
- R1: While reset is asserted, and after its release until the first pattern starts, `shift_en`, `capture` and `underrun` are low, and all head cells (`cell_q`) and spare cells (`spare_q`) read zero.
- R2: A pattern begins only when `pat_start` is high while `test_mode` is high and the block is idle. A word presented while idle has no effect on `cell_q`.
- R3: When a word is accepted, chain j's head cells load word bits `[j*P_IN +: P_IN]`. Head cell b of chain j appears at `cell_q[j*P_IN + b]`.
- R4: In the i-th of the `P_IN` cycles after a non-final word is accepted (i from 0), `shift_en` is high and `scan_bit[j]` equals word bit `j*P_IN + P_IN-1-i`. Zeros enter the head cell of each chain.
- R5: A word that is valid in the last cycle of a shift window is accepted at that clock edge. The next window follows with no gap in `shift_en`.
- R6: If no word is valid in the last cycle of a window, `underrun` is high for exactly the next cycle. `shift_en` then stays low until a word is accepted.
- R7: Words presented in the earlier cycles of a shift window are ignored: the bits being shifted are unchanged.
- R8: A word accepted with `word_last` high is loaded and not shifted. `shift_en` stays low, `cell_q` holds the word, and `capture` is high for exactly the next cycle. The block is then idle.
- R9: The top `W_IN mod N_CH` word bits are loaded only into `spare_q`, and never reach `scan_bit` or `cell_q`.
- R10: With `test_mode` low the block goes idle: no shifting, no capture, and `pat_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Enables stimulus loading |
| pat_start | input | 1 | Begins a new pattern |
| word_valid | input | 1 | Word present on `word_data` |
| word_last | input | 1 | Marks the final word of a pattern |
| word_data | input | W_IN | Stimulus word from the interconnect port |
| shift_en | output | 1 | Chain shift enable |
| scan_bit | output | N_CH | Per-chain bit leaving the head cells |
| cell_q | output | N_CH*P_IN | Head cell contents applied to the module |
| spare_q | output | max(W_IN mod N_CH,1) | Spare cells holding the leftover bits |
| capture | output | 1 | One-cycle launch/capture trigger |
| underrun | output | 1 | Next word was late |

## Verification
A continuous stream of three words with distinct per-chain bit patterns shows that each slice is mapped and shifted in the right order, and that back-to-back acceptance leaves no gap. A late word separates the underrun path from normal streaming, and a word sent in mid-window shows that early words are ignored. A final word whose only set bits are the leftover ones tells the spare cells apart from the chain cells. Dropping test mode, both while idle and during shifting, shows that the block returns to idle.

// File: rtl/scan_stim_pkg.sv
package scan_stim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_CAPT  = 2'd3
  } ld_state_e;
endpackage

// File: rtl/scan_stim_ctrl.sv
module scan_stim_ctrl
  import scan_stim_pkg::*;
#(
  parameter int P_IN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  input  logic pat_start,
  input  logic word_valid,
  input  logic word_last,
  output logic load,
  output logic shift,
  output logic shift_en,
  output logic capture,
  output logic underrun
);
  localparam int CW = (P_IN > 1) ? $clog2(P_IN) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(P_IN - 1);

  ld_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic und_q, und_d;
  logic win_end;

  assign win_end = (st_q == ST_SHIFT) && (cnt_q == LAST_CNT);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    und_d = 1'b0;
    load  = 1'b0;
    if (!test_mode) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (pat_start) st_d = ST_WAIT;
        ST_WAIT: begin
          if (word_valid) begin
            load  = 1'b1;
            st_d  = word_last ? ST_CAPT : ST_SHIFT;
            cnt_d = '0;
          end
        end
        ST_SHIFT: begin
          if (win_end) begin
            if (word_valid) begin
              load  = 1'b1;
              st_d  = word_last ? ST_CAPT : ST_SHIFT;
              cnt_d = '0;
            end else begin
              st_d  = ST_WAIT;
              und_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign shift_en = (st_q == ST_SHIFT);
  assign shift    = shift_en && !load;
  assign capture  = (st_q == ST_CAPT);
  assign underrun = und_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      und_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      und_q <= und_d;
    end
  end
endmodule

// File: rtl/scan_stim_head.sv
module scan_stim_head #(
  parameter int P_IN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            shift,
  input  logic [P_IN-1:0] slice,
  output logic [P_IN-1:0] cells,
  output logic            sout
);
  logic [P_IN-1:0] cell_q, cell_d;

  always_comb begin
    cell_d = cell_q;
    if (load) begin
      cell_d = slice;
    end else if (shift) begin
      cell_d = cell_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cell_q <= '0;
    else        cell_q <= cell_d;
  end

  assign cells = cell_q;
  assign sout  = cell_q[P_IN-1];
endmodule

// File: rtl/scan_stim_loader.sv
module scan_stim_loader #(
  parameter int W_IN = 32,
  parameter int N_CH = 10,
  parameter int P_IN = W_IN / N_CH,
  parameter int N_PAD = W_IN % N_CH,
  parameter int PAD_W = (N_PAD > 0) ? N_PAD : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 test_mode,
  input  logic                 pat_start,
  input  logic                 word_valid,
  input  logic                 word_last,
  input  logic [W_IN-1:0]      word_data,
  output logic                 shift_en,
  output logic [N_CH-1:0]      scan_bit,
  output logic [N_CH*P_IN-1:0] cell_q,
  output logic [PAD_W-1:0]     spare_q,
  output logic                 capture,
  output logic                 underrun
);
  localparam int USED = N_CH * P_IN;

  // Reset asserts at once and leaves on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  logic load, shift;

  scan_stim_ctrl #(.P_IN(P_IN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .test_mode  (test_mode),
    .pat_start  (pat_start),
    .word_valid (word_valid),
    .word_last  (word_last),
    .load       (load),
    .shift      (shift),
    .shift_en   (shift_en),
    .capture    (capture),
    .underrun   (underrun)
  );

  for (genvar j = 0; j < N_CH; j++) begin : g_chain
    scan_stim_head #(.P_IN(P_IN)) u_head (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .load  (load),
      .shift (shift),
      .slice (word_data[j*P_IN +: P_IN]),
      .cells (cell_q[j*P_IN +: P_IN]),
      .sout  (scan_bit[j])
    );
  end

  if (N_PAD > 0) begin : g_spare
    logic [PAD_W-1:0] spare_r, spare_d;
    always_comb begin
      spare_d = spare_r;
      if (load) spare_d = word_data[W_IN-1:USED];
    end
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) spare_r <= '0;
      else             spare_r <= spare_d;
    end
    assign spare_q = spare_r;
  end else begin : g_nospare
    assign spare_q = '0;
  end
endmodule

// File: rtl/scan_stim_loader_chk.sv
module scan_stim_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic test_mode,
  input logic word_valid,
  input logic word_last,
  input logic shift_en,
  input logic capture,
  input logic underrun
);
  // R8: capture lasts one cycle
  a_r8_capture_single: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);
  // R8: capture only after an accepted final word
  a_r8_capture_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture) |-> $past(word_valid && word_last));
  // R8: no shifting while capturing
  a_r8_no_shift_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !shift_en);
  // R6: underrun stops shifting and lasts one cycle
  a_r6_underrun_stall: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!shift_en && !capture));
  a_r6_underrun_single: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);
  // R4: a shift window opens only after a word was presented
  a_r4_shift_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_en) |-> $past(word_valid && !word_last));
  // R10: leaving test mode idles the block
  a_r10_mode_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> (!shift_en && !capture));
endmodule

bind scan_stim_loader scan_stim_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .test_mode  (test_mode),
  .word_valid (word_valid),
  .word_last  (word_last),
  .shift_en   (shift_en),
  .capture    (capture),
  .underrun   (underrun)
);

// File: tb/scan_stim_loader_bench.sv
module scan_stim_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W_IN = 32;
  localparam int N_CH = 10;
  localparam int P_IN = W_IN / N_CH;
  localparam int USED = N_CH * P_IN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0, pat_start = 1'b0, word_valid = 1'b0, word_last = 1'b0;
  logic [W_IN-1:0] word_data = '0;
  logic shift_en, capture, underrun;
  logic [N_CH-1:0] scan_bit;
  logic [USED-1:0] cell_q;
  logic [1:0] spare_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_stim_loader #(.W_IN(W_IN), .N_CH(N_CH)) u_scan_stim_loader (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .pat_start(pat_start),
    .word_valid(word_valid), .word_last(word_last), .word_data(word_data),
    .shift_en(shift_en), .scan_bit(scan_bit), .cell_q(cell_q), .spare_q(spare_q),
    .capture(capture), .underrun(underrun));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N_CH-1:0] exp_bits(input logic [W_IN-1:0] w, input int i);
    logic [N_CH-1:0] v;
    for (int j = 0; j < N_CH; j++) v[j] = w[j*P_IN + P_IN-1-i];
    return v;
  endfunction

  task automatic start_pattern();
    pat_start = 1'b1; tick(); pat_start = 1'b0;
  endtask

  task automatic t_reset();
    tick(); tick();
    chk("R1 shift_en", 64'(shift_en), 0);
    chk("R1 capture", 64'(capture), 0);
    chk("R1 cells", 64'(cell_q), 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R1 underrun after release", 64'(underrun), 0);
    chk("R1 spare", 64'(spare_q), 0);
  endtask

  task automatic t_stream();
    logic [W_IN-1:0] a = 32'h1234_5678, b = 32'hA5C3_0F96, c = 32'h3B6D_91E4;
    test_mode = 1'b1;
    start_pattern();
    word_data = a; word_valid = 1'b1; tick(); word_valid = 1'b0;
    chk("R3 slice load", 64'(cell_q), 64'(a[USED-1:0]));
    chk("R4 shift_en on", 64'(shift_en), 1);
    chk("R4 bit cycle 0", 64'(scan_bit), 64'(exp_bits(a, 0)));
    tick();
    chk("R4 bit cycle 1", 64'(scan_bit), 64'(exp_bits(a, 1)));
    tick();
    chk("R4 bit cycle 2", 64'(scan_bit), 64'(exp_bits(a, 2)));
    word_data = b; word_valid = 1'b1; tick(); word_valid = 1'b0;
    chk("R5 no gap", 64'(shift_en), 1);
    chk("R5 next word bits", 64'(scan_bit), 64'(exp_bits(b, 0)));
    chk("R5 no underrun", 64'(underrun), 0);
    tick(); tick();
    word_data = c; word_valid = 1'b1; word_last = 1'b1; tick();
    word_valid = 1'b0; word_last = 1'b0;
    chk("R8 no shift on last", 64'(shift_en), 0);
    chk("R8 capture", 64'(capture), 1);
    chk("R8 cells hold final", 64'(cell_q), 64'(c[USED-1:0]));
    tick();
    chk("R8 capture one cycle", 64'(capture), 0);
    word_data = 32'hFFFF_FFFF; word_valid = 1'b1; tick(); word_valid = 1'b0;
    chk("R2 idle word ignored", 64'(cell_q), 64'(c[USED-1:0]));
    chk("R2 idle no shift", 64'(shift_en), 0);
  endtask

  task automatic t_underrun();
    logic [W_IN-1:0] a = 32'h0F0F_3C3C, b = 32'h2468_ACE1, e = 32'h1357_9BDF;
    start_pattern();
    word_data = a; word_valid = 1'b1; tick(); word_valid = 1'b0;
    tick(); tick(); tick();
    chk("R6 underrun pulse", 64'(underrun), 1);
    chk("R6 shift stops", 64'(shift_en), 0);
    chk("R4 zeros shifted in", 64'(cell_q), 0);
    tick();
    chk("R6 underrun one cycle", 64'(underrun), 0);
    chk("R6 still waiting", 64'(shift_en), 0);
    word_data = b; word_valid = 1'b1; tick(); word_valid = 1'b0;
    chk("R6 resume", 64'(scan_bit), 64'(exp_bits(b, 0)));
    word_data = e; word_valid = 1'b1; tick(); word_valid = 1'b0;
    chk("R7 early word ignored", 64'(scan_bit), 64'(exp_bits(b, 1)));
    tick();
    chk("R7 window intact", 64'(scan_bit), 64'(exp_bits(b, 2)));
    word_data = e; word_valid = 1'b1; word_last = 1'b1; tick();
    word_valid = 1'b0; word_last = 1'b0;
    chk("R8 capture after stream", 64'(capture), 1);
    tick();
  endtask

  task automatic t_leftover();
    start_pattern();
    word_data = 32'hC000_0000; word_valid = 1'b1; word_last = 1'b1; tick();
    word_valid = 1'b0; word_last = 1'b0;
    chk("R9 spare gets leftover", 64'(spare_q), 64'h3);
    chk("R9 cells untouched", 64'(cell_q), 0);
    chk("R9 scan bits untouched", 64'(scan_bit), 0);
    tick();
  endtask

  task automatic t_mode();
    logic [USED-1:0] held;
    held = cell_q;
    test_mode = 1'b0;
    start_pattern();
    word_data = 32'h2AAA_AAAA; word_valid = 1'b1; tick(); word_valid = 1'b0;
    chk("R10 start ignored", 64'(shift_en), 0);
    chk("R10 cells unchanged", 64'(cell_q), 64'(held));
    test_mode = 1'b1;
    start_pattern();
    word_data = 32'h1555_5555; word_valid = 1'b1; tick(); word_valid = 1'b0;
    chk("R10 shifting before drop", 64'(shift_en), 1);
    test_mode = 1'b0; tick();
    chk("R10 drop stops shift", 64'(shift_en), 0);
    test_mode = 1'b1;
    word_valid = 1'b1; tick(); word_valid = 1'b0;
    chk("R10 idle after drop", 64'(shift_en), 0);
    chk("R10 no capture", 64'(capture), 0);
  endtask

  initial begin
    t_reset();
    t_stream();
    t_underrun();
    t_leftover();
    t_mode();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule